// File: doc/BRIEF.md
# Circular Window Sum Engine

The engine keeps an array of up to `MAX_N` signed words. For every position of that array it produces a replacement value: the sum of a run of neighbouring elements. The run's direction and length come from a signed key. A positive key sums the elements that come after the position. A negative key sums the elements that come before it. A zero key yields zero. Positions wrap around both ends of the array, so the array is treated as a ring.

Software or a neighbouring block fills the array through a single write port while the engine is idle. It then presents the length and the key together with a one-cycle start pulse. The engine walks the positions in ascending order. For each position it runs an inner counting loop of |key| accumulation steps and then offers the sum on a valid/ready stream. A one-cycle done pulse follows the last accepted result. Every sum is formed from the array as it was loaded; results never overwrite the stored values.

Top module: `cws_engine`

## Requirements
- R1: After reset, busy_o, res_valid_o, done_o and err_o are all low.
- R2: With key k > 0, result i equals the sum of elements i+1 through i+k, taken circularly.
- R3: With key k < 0, result i equals the sum of elements i-1 down to i-|k|, taken circularly.
- R4: With key 0, every result is 0. With ready held high, one result is delivered per cycle.
- R5: Indices wrap: the element after n-1 is 0 and the element before 0 is n-1. Results leave in ascending index order, n of them.
- R6: While busy_o is high, writes on the load port are ignored, so results depend only on the values loaded before start.
- R7: A start with n = 0, n > MAX_N or |k| >= n raises err_o for exactly the next cycle. It produces no result and leaves busy_o low.
- R8: Sums are formed as 32-bit two's complement and wrap on overflow.
- R9: While res_valid_o is high and res_ready_i is low, res_valid_o stays high and res_data_o holds its value.
- R10: done_o rises for exactly one cycle, the cycle after the last result is accepted.
- R11: With res_ready_i held high, done_o is seen n·(|k|+1)+1 cycles after the start edge, and each result costs |k|+1 cycles.
- R12: A start pulse that arrives while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Array write strobe, honoured only while idle |
| wr_addr_i | input | IDX_W | Element index to write |
| wr_data_i | input | DATA_W | Element value |
| len_i | input | IDX_W+1 | Array length n, sampled at start |
| key_i | input | IDX_W+1 | Signed key k (two's complement), sampled at start |
| start_i | input | 1 | One-cycle start request |
| busy_o | output | 1 | Computation in progress |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | DATA_W | Result value, signed |
| done_o | output | 1 | One-cycle pulse after the final result is accepted |
| err_o | output | 1 | One-cycle pulse after a rejected start |

## Verification
A faulty wrap pointer or a wrong direction bit shows up in the very first result whose window crosses an array end. For key 3 over four elements, that is result 1. An inner counter that is off by one makes every sum wrong. It also moves the valid edge and the done pulse away from the n·(|k|+1)+1 cycle mark, so the cycle-counted check catches it even when the sums happen to agree. A store that is not locked during a run, or a start that is not ignored while busy, corrupts a later result. Backpressure faults break the hold rule on the first stalled cycle.

// File: rtl/cws_pkg.sv
package cws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SUM,
    ST_EMIT,
    ST_DONE
  } cws_state_e;
endpackage

// File: rtl/cws_store.sv
module cws_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cws_wrap.sv
// Circular single step: forward or backward within [0, len-1]
module cws_wrap #(
  parameter int IDX_W = 5,
  parameter int LEN_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             back_i,
  output logic [IDX_W-1:0] nxt_o
);
  logic [IDX_W-1:0] last;
  assign last = IDX_W'(len_i - LEN_W'(1));

  always_comb begin
    if (back_i) nxt_o = (idx_i == '0)   ? last : idx_i - IDX_W'(1);
    else        nxt_o = (idx_i == last) ? '0   : idx_i + IDX_W'(1);
  end
endmodule

// File: rtl/cws_acc.sv
module cws_acc #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (add_i) acc_o <= acc_o + val_i;  // modular, wraps
  end
endmodule

// File: rtl/cws_engine.sv
module cws_engine
  import cws_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAX_N  = 32,
  localparam int IDX_W = $clog2(MAX_N),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LEN_W-1:0]  key_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic              done_o,
  output logic              err_o
);
  cws_state_e        state_q;
  logic [LEN_W-1:0]  n_q, kabs_q, cnt_q;
  logic              back_q, err_q;
  logic [IDX_W-1:0]  i_q, ptr_q;

  logic [LEN_W-1:0]  key_abs, len_sel;
  logic              cfg_bad, back_sel, idle, go, accept, i_last;
  logic [IDX_W-1:0]  seed_idx, seed_nxt, ptr_nxt, last_idx;
  logic [DATA_W-1:0] rdata, acc;

  assign idle     = (state_q == ST_IDLE);
  assign key_abs  = key_i[LEN_W-1] ? LEN_W'(-key_i) : key_i;
  assign cfg_bad  = (len_i == '0) || (len_i > LEN_W'(MAX_N)) || (key_abs >= len_i);
  assign go       = idle && start_i && !cfg_bad;
  assign accept   = (state_q == ST_EMIT) && res_ready_i;
  assign last_idx = IDX_W'(n_q - LEN_W'(1));
  assign i_last   = (i_q == last_idx);

  // seed points at the first window element of the next outer index
  assign len_sel  = idle ? len_i : n_q;
  assign back_sel = idle ? key_i[LEN_W-1] : back_q;
  assign seed_idx = idle ? '0 : i_q + IDX_W'(1);

  cws_wrap #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_seed (
    .idx_i(seed_idx), .len_i(len_sel), .back_i(back_sel), .nxt_o(seed_nxt)
  );

  cws_wrap #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_step (
    .idx_i(ptr_q), .len_i(n_q), .back_i(back_q), .nxt_o(ptr_nxt)
  );

  // array is frozen outside idle
  cws_store #(.DATA_W(DATA_W), .DEPTH(MAX_N), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_en_i && idle),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (ptr_q),
    .rdata_o (rdata)
  );

  cws_acc #(.DATA_W(DATA_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (go || accept),
    .add_i  (state_q == ST_SUM),
    .val_i  (rdata),
    .acc_o  (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      kabs_q  <= '0;
      cnt_q   <= '0;
      back_q  <= 1'b0;
      err_q   <= 1'b0;
      i_q     <= '0;
      ptr_q   <= '0;
    end else begin
      err_q <= idle && start_i && cfg_bad;
      unique case (state_q)
        ST_IDLE: if (go) begin
          n_q     <= len_i;
          kabs_q  <= key_abs;
          cnt_q   <= key_abs;
          back_q  <= key_i[LEN_W-1];
          i_q     <= '0;
          ptr_q   <= seed_nxt;
          state_q <= (key_abs == '0) ? ST_EMIT : ST_SUM;
        end
        ST_SUM: begin
          ptr_q <= ptr_nxt;
          cnt_q <= cnt_q - LEN_W'(1);
          if (cnt_q == LEN_W'(1)) state_q <= ST_EMIT;
        end
        ST_EMIT: if (res_ready_i) begin
          if (i_last) begin
            state_q <= ST_DONE;
          end else begin
            i_q     <= i_q + IDX_W'(1);
            ptr_q   <= seed_nxt;
            cnt_q   <= kabs_q;
            state_q <= (kabs_q == '0) ? ST_EMIT : ST_SUM;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = !idle;
  assign res_valid_o = (state_q == ST_EMIT);
  assign res_data_o  = acc;
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = err_q;

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_data_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !res_valid_o);

  // R7
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !res_valid_o);

  // R4
  zero_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && (kabs_q == '0) |-> res_data_o == '0);

  // R5
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> LEN_W'(ptr_q) < n_q);

  // R12
  start_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> !err_o && $stable(n_q) && $stable(kabs_q));
endmodule

// File: tb/cws_engine_bench.sv
`timescale 1ns/1ps
module cws_engine_bench;
  localparam int DW = 32;
  localparam int MN = 32;
  localparam int IW = $clog2(MN);
  localparam int LW = IW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] len = '0;
  logic [LW-1:0] key = '0;
  logic          start = 1'b0;
  logic          busy, rvalid, done, err;
  logic          rready = 1'b0;
  logic [DW-1:0] rdata;

  int total = 0;
  int bad = 0;
  int arr[MN];

  always #2 clk = ~clk;

  cws_engine #(.DATA_W(DW), .MAX_N(MN)) u_cws_engine (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .len_i(len), .key_i(key), .start_i(start),
    .busy_o(busy), .res_valid_o(rvalid), .res_ready_i(rready),
    .res_data_o(rdata), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = IW'(i); wr_data = arr[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // rmode 0: ready always high; 1: ready low every third cycle
  task automatic run_case(input int n, input int k, input int rmode, input bit disturb,
                          input string tag);
    int exp_q[$];
    int got[$];
    int ka, s, idx, cyc, done_cyc;
    bit stall;
    logic [DW-1:0] held;
    ka = (k < 0) ? -k : k;
    for (int i = 0; i < n; i++) begin
      s = 0;
      for (int j = 1; j <= ka; j++) begin
        idx = (k > 0) ? (i + j) % n : (((i - j) % n) + n) % n;
        s += arr[idx];
      end
      exp_q.push_back(s);
    end
    @(negedge clk);
    len = LW'(n); key = LW'(k); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; done_cyc = -1; stall = 1'b0; held = '0;
    while (cyc < 4000) begin
      if (disturb && cyc == 3) begin
        wr_en = 1'b1; wr_addr = '0; wr_data = 32'h0000_5555;
        start = 1'b1; key = '0;  // R6 R12: must be ignored
      end else begin
        wr_en = 1'b0; start = 1'b0;
      end
      rready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (stall) chk(rvalid && rdata == held, "R9 hold", int'(rdata), int'(held));
      if (done) begin done_cyc = cyc; break; end
      if (rvalid && rready) got.push_back(int'(rdata));
      stall = rvalid && !rready;
      held = rdata;
      @(negedge clk);
      cyc++;
    end
    wr_en = 1'b0; start = 1'b0; rready = 1'b0;
    chk(done_cyc > 0, "R10 done seen", done_cyc, 1);
    chk(got.size() == n, {tag, " R5 count"}, got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      chk(got[i] == exp_q[i], {tag, " R5 value"}, got[i], exp_q[i]);
    if (rmode == 0)
      chk(done_cyc == n * (ka + 1) + 1, "R11 cycles", done_cyc, n * (ka + 1) + 1);
    @(negedge clk);
    chk(!done, "R10 single pulse", int'(done), 0);
    chk(!busy, "R10 idle after done", int'(busy), 0);
  endtask

  task automatic run_bad(input int n, input int k);
    @(negedge clk);
    len = LW'(n); key = LW'(k); start = 1'b1; rready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err, "R7 err raised", int'(err), 1);
    chk(!busy && !rvalid, "R7 no run", int'(busy || rvalid), 0);
    @(negedge clk);
    chk(!err, "R7 err one cycle", int'(err), 0);
    repeat (4) @(negedge clk);
    chk(!rvalid && !busy, "R7 no output", int'(rvalid || busy), 0);
    rready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog all act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rvalid && !done && !err, "R1 reset",
        int'({busy, rvalid, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rvalid && !done && !err, "R1 after release",
        int'({busy, rvalid, done, err}), 0);

    arr[0] = 5; arr[1] = 7; arr[2] = 1; arr[3] = 4;
    load(4);
    run_case(4, 3, 0, 1'b0, "R2");      // 12 10 16 13
    run_case(4, -1, 0, 1'b0, "R3");     // 4 5 7 1
    run_case(4, 0, 0, 1'b0, "R4");
    run_case(4, 0, 1, 1'b0, "R4 R9");
    run_case(4, -3, 1, 1'b0, "R3 R9");
    run_bad(4, 4);
    run_bad(4, -4);
    run_bad(0, 0);
    run_bad(33, 1);

    arr[0] = 9;
    load(1);
    run_case(1, 0, 0, 1'b0, "R4 single");

    arr[0] = 32'h7fff_ffff; arr[1] = 1; arr[2] = 2;
    load(3);
    run_case(3, 1, 0, 1'b0, "R8");
    run_case(3, -2, 0, 1'b0, "R8 back");

    for (int i = 0; i < 5; i++) arr[i] = (i + 1) * 10 - 27;
    load(5);
    run_case(5, 2, 0, 1'b1, "R6 R12");
    run_case(5, -4, 1, 1'b1, "R6 R12 R9");

    for (int i = 0; i < MN; i++) arr[i] = (i * 7919) ^ (i << 20) - 1000;
    load(MN);
    run_case(MN, -31, 1, 1'b1, "R3 R6 full");
    run_case(MN, 31, 0, 1'b0, "R2 full");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule